// File: doc/BRIEF.md
# Framebuffer Controller Register File

This block holds the configuration of a raster video framebuffer controller. A host reaches it over a simple 32-bit bus. The bus carries a byte address, a write strobe and a read strobe, and all accesses are full words. The settings are:
- a control word whose lowest bit holds the controller halted
- the visible width and height
- the sync start and end positions and the total scan lengths, horizontal and vertical
- the framebuffer base address
- a burst count, a display-data-channel word and a pixel source clock selector

Downstream scan-out logic takes its configuration from four outputs:
- `running`, high while the controller is released
- the current base address
- the line stride in bytes
- two single-cycle event pulses: `reconfigure` when control or geometry changes while the controller runs, and `refresh_req` when a new base address is accepted

The base address must be 32-byte aligned, and a write that breaks this rule is dropped. An accepted base value is ANDed with a mask parameter. A read-only register mirrors the base address that is in use. An access outside the register set is flagged on `bad_access`. Read data is registered and appears in the cycle after the read strobe.

Top module: `fb_cfg_regs`

## Requirements
- R1: After reset, control reads 1, width (index 1) reads 640 and height (index 5) reads 480. Every other register reads 0, `running` is 0 and `base_addr` is 0.
- R2: The register index is the byte address shifted right by two. The index map is:
  - 0: control
  - 1: width
  - 2: horizontal sync start
  - 3: horizontal sync end
  - 4: horizontal total
  - 5: height
  - 6: vertical sync start
  - 7: vertical sync end
  - 8: vertical total
  - 9: base
  - 10: live base
  - 11: burst
  - 12: data-channel word
  - 13: source clock

  A written value reads back unchanged. `rdata` is valid in the cycle after `rd_en`.
- R3: `running` is high exactly while bit 0 of the control register is 0.
- R4: A base write (index 9) whose data has any of bits 4:0 set is discarded. The base keeps its old value and no `refresh_req` follows.
- R5: An accepted base write stores `wdata & BASE_MASK`, and the stored value drives `base_addr`.
- R6: Reading index 10 returns the current base. Writes to index 10 change nothing.
- R7: `reconfigure` pulses for one cycle after a write to index 0, 1 or 5, but only when the controller is running once that write has taken effect.
- R8: `refresh_req` pulses for one cycle after every accepted base write, whether or not the controller is running.
- R9: `line_stride` equals the width times 2.
- R10: An access is bad in either of these cases:
  - the byte address has bits 1:0 nonzero
  - the index is 14 or above

  A bad read returns 0 and a bad write changes no register. In both cases `bad_access` pulses for one cycle after the access.
- R11: The reset is synchronous and active-high. One cycle of reset restores every reset value from R1.
- R12: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| running | output | 1 | Controller released from halt |
| base_addr | output | 32 | Current framebuffer base |
| line_stride | output | 32 | Bytes per line (width times 2) |
| reconfigure | output | 1 | Geometry/control change pulse |
| refresh_req | output | 1 | Full-frame refresh pulse |
| bad_access | output | 1 | Undefined or partial access pulse |

## Verification
A read and a write can land on the same register in the same cycle. The bench raises both strobes together on the data-channel word. It then checks that the registered read returns the old contents, and that a following read returns the new value (R12). Two more events can share one clock edge: a write to the control word that releases the halt, and the resulting pulse. The bench checks that `running` and `reconfigure` rise on the same edge. It also checks that a halting control write produces no pulse.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    localparam int WORD_W     = 32;
    localparam int IDX_W      = 4;
    localparam int NUM_REGS   = 14;
    localparam int ALIGN_BITS = 5;
    localparam int IDX_LSB    = 2;

    typedef enum logic [IDX_W-1:0] {
        IX_CTRL      = 4'd0,
        IX_HRES      = 4'd1,
        IX_HSYNC_ON  = 4'd2,
        IX_HSYNC_OFF = 4'd3,
        IX_HTOTAL    = 4'd4,
        IX_VRES      = 4'd5,
        IX_VSYNC_ON  = 4'd6,
        IX_VSYNC_OFF = 4'd7,
        IX_VTOTAL    = 4'd8,
        IX_BASE      = 4'd9,
        IX_BASE_LIVE = 4'd10,
        IX_BURST     = 4'd11,
        IX_DDC       = 4'd12,
        IX_SRCCLK    = 4'd13
    } reg_ix_e;

    typedef struct packed {
        logic    hit;
        reg_ix_e ix;
    } dec_t;

    typedef struct packed {
        logic [WORD_W-1:0] ctrl;
        logic [WORD_W-1:0] hres;
        logic [WORD_W-1:0] hsync_on;
        logic [WORD_W-1:0] hsync_off;
        logic [WORD_W-1:0] htotal;
        logic [WORD_W-1:0] vres;
        logic [WORD_W-1:0] vsync_on;
        logic [WORD_W-1:0] vsync_off;
        logic [WORD_W-1:0] vtotal;
        logic [WORD_W-1:0] base;
        logic [WORD_W-1:0] burst;
        logic [WORD_W-1:0] ddc;
        logic [WORD_W-1:0] srcclk;
    } cfg_t;

    function automatic logic base_aligned(input logic [WORD_W-1:0] v);
        return v[ALIGN_BITS-1:0] == '0;
    endfunction

    function automatic cfg_t cfg_defaults(input logic [WORD_W-1:0] w,
                                          input logic [WORD_W-1:0] h);
        cfg_t c;
        c      = '0;
        c.ctrl = 32'd1;
        c.hres = w;
        c.vres = h;
        return c;
    endfunction

endpackage

// File: rtl/fbr_decode.sv
module fbr_decode
    import fbr_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam int TOP_LSB = IDX_LSB + IDX_W;

    logic upper_ok;
    logic [IDX_W-1:0] raw_ix;

    generate
        if (ADDR_W > TOP_LSB) begin : g_wide
            assign upper_ok = (addr[ADDR_W-1:TOP_LSB] == '0);
        end else begin : g_exact
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign raw_ix = addr[TOP_LSB-1:IDX_LSB];

    always_comb begin
        dec.ix  = reg_ix_e'(raw_ix);
        dec.hit = upper_ok && (addr[IDX_LSB-1:0] == '0)
                  && (int'(raw_ix) < NUM_REGS);
    end
endmodule

// File: rtl/fbr_bank.sv
module fbr_bank
    import fbr_pkg::*;
#(
    parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
    parameter logic [31:0] RST_HRES  = 32'd640,
    parameter logic [31:0] RST_VRES  = 32'd480
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  dec_t              dec,
    input  logic [WORD_W-1:0] wdata,
    output cfg_t              cfg,
    output logic              running,
    output logic              reconfigure,
    output logic              refresh_req
);
    assign running = ~cfg.ctrl[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg         <= cfg_defaults(RST_HRES, RST_VRES);
            reconfigure <= 1'b0;
            refresh_req <= 1'b0;
        end else begin
            reconfigure <= 1'b0;
            refresh_req <= 1'b0;
            if (wr_en && dec.hit) begin
                unique case (dec.ix)
                    IX_CTRL: begin
                        cfg.ctrl    <= wdata;
                        reconfigure <= ~wdata[0];
                    end
                    IX_HRES: begin
                        cfg.hres    <= wdata;
                        reconfigure <= running;
                    end
                    IX_VRES: begin
                        cfg.vres    <= wdata;
                        reconfigure <= running;
                    end
                    IX_HSYNC_ON:  cfg.hsync_on  <= wdata;
                    IX_HSYNC_OFF: cfg.hsync_off <= wdata;
                    IX_HTOTAL:    cfg.htotal    <= wdata;
                    IX_VSYNC_ON:  cfg.vsync_on  <= wdata;
                    IX_VSYNC_OFF: cfg.vsync_off <= wdata;
                    IX_VTOTAL:    cfg.vtotal    <= wdata;
                    IX_BASE: begin
                        if (base_aligned(wdata)) begin
                            cfg.base    <= wdata & BASE_MASK;
                            refresh_req <= 1'b1;
                        end
                    end
                    IX_BASE_LIVE: ;
                    IX_BURST:     cfg.burst  <= wdata;
                    IX_DDC:       cfg.ddc    <= wdata;
                    IX_SRCCLK:    cfg.srcclk <= wdata;
                    default: ;
                endcase
            end
        end
    end

    // R7
    reconf_run_chk: assert property (@(posedge clk) disable iff (rst)
        reconfigure |-> running);

    // R8
    refresh_cause_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_req |-> $past(wr_en && dec.hit && dec.ix == IX_BASE));

    // R4
    misaligned_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && dec.hit && dec.ix == IX_BASE && wdata[ALIGN_BITS-1:0] != '0)
        |=> ($stable(cfg.base) && !refresh_req));

    // R5
    base_shape_chk: assert property (@(posedge clk) disable iff (rst)
        ((cfg.base & ~BASE_MASK) == '0) && (cfg.base[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/fbr_rdmux.sv
module fbr_rdmux
    import fbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  dec_t              dec,
    input  cfg_t              cfg,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] sel;

    always_comb begin
        unique case (dec.ix)
            IX_CTRL:      sel = cfg.ctrl;
            IX_HRES:      sel = cfg.hres;
            IX_HSYNC_ON:  sel = cfg.hsync_on;
            IX_HSYNC_OFF: sel = cfg.hsync_off;
            IX_HTOTAL:    sel = cfg.htotal;
            IX_VRES:      sel = cfg.vres;
            IX_VSYNC_ON:  sel = cfg.vsync_on;
            IX_VSYNC_OFF: sel = cfg.vsync_off;
            IX_VTOTAL:    sel = cfg.vtotal;
            IX_BASE,
            IX_BASE_LIVE: sel = cfg.base;
            IX_BURST:     sel = cfg.burst;
            IX_DDC:       sel = cfg.ddc;
            IX_SRCCLK:    sel = cfg.srcclk;
            default:      sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= dec.hit ? sel : '0;
        end
    end

    // R10
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !dec.hit) |=> (rdata == '0));
endmodule

// File: rtl/fb_cfg_regs.sv
module fb_cfg_regs
    import fbr_pkg::*;
#(
    parameter int          ADDR_W    = 6,
    parameter logic [31:0] BASE_MASK = 32'hFFFF_FFFF,
    parameter logic [31:0] RST_HRES  = 32'd640,
    parameter logic [31:0] RST_VRES  = 32'd480
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              running,
    output logic [31:0]       base_addr,
    output logic [31:0]       line_stride,
    output logic              reconfigure,
    output logic              refresh_req,
    output logic              bad_access
);
    dec_t dec;
    cfg_t cfg;

    fbr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    fbr_bank #(
        .BASE_MASK (BASE_MASK),
        .RST_HRES  (RST_HRES),
        .RST_VRES  (RST_VRES)
    ) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .dec         (dec),
        .wdata       (wdata),
        .cfg         (cfg),
        .running     (running),
        .reconfigure (reconfigure),
        .refresh_req (refresh_req)
    );

    fbr_rdmux u_rd (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rd_en),
        .dec   (dec),
        .cfg   (cfg),
        .rdata (rdata)
    );

    assign base_addr   = cfg.base;
    assign line_stride = {cfg.hres[30:0], 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_access <= 1'b0;
        end else begin
            bad_access <= (wr_en || rd_en) && !dec.hit;
        end
    end

    // R10
    bad_cause_chk: assert property (@(posedge clk) disable iff (rst)
        bad_access |-> $past(wr_en || rd_en));
endmodule

// File: tb/fb_cfg_regs_test.sv
module fb_cfg_regs_test;
    localparam logic [31:0] MASK = 32'h0FFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, base_addr, line_stride;
    logic        running, reconfigure, refresh_req, bad_access;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fb_cfg_regs #(.ADDR_W(6), .BASE_MASK(MASK)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .running(running),
        .base_addr(base_addr), .line_stride(line_stride),
        .reconfigure(reconfigure), .refresh_req(refresh_req),
        .bad_access(bad_access)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic t_reset_values();
        logic [31:0] v;
        for (int i = 0; i < 14; i++) begin
            rd(6'(i * 4), v);
            chk($sformatf("R1 reset idx %0d", i), v,
                (i == 0) ? 32'd1 : (i == 1) ? 32'd640 : (i == 5) ? 32'd480 : 32'd0);
        end
        chk("R1 running", {31'd0, running}, 32'd0);
        chk("R1 base", base_addr, 32'd0);
        chk("R9 stride at reset", line_stride, 32'd1280);
    endtask

    task automatic t_map_order();
        logic [31:0] v;
        for (int i = 1; i < 14; i++) begin
            if (i != 9 && i != 10) wr(6'(i * 4), 32'hA500_0000 + 32'(i * 17));
        end
        for (int i = 1; i < 14; i++) begin
            if (i != 9 && i != 10) begin
                rd(6'(i * 4), v);
                chk($sformatf("R2 readback idx %0d", i), v, 32'hA500_0000 + 32'(i * 17));
            end
        end
        wr(6'h04, 32'd320);
        chk("R7 halted hres write no pulse", {31'd0, reconfigure}, 32'd0);
        wr(6'h14, 32'd240);
        chk("R7 halted vres write no pulse", {31'd0, reconfigure}, 32'd0);
    endtask

    task automatic t_run_reconfig();
        wr(6'h00, 32'd0);
        chk("R3 running after release", {31'd0, running}, 32'd1);
        chk("R7 release pulse", {31'd0, reconfigure}, 32'd1);
        @(negedge clk);
        chk("R7 pulse one cycle", {31'd0, reconfigure}, 32'd0);
        wr(6'h04, 32'd800);
        chk("R7 running hres pulse", {31'd0, reconfigure}, 32'd1);
        chk("R9 stride 800", line_stride, 32'd1600);
        wr(6'h14, 32'd600);
        chk("R7 running vres pulse", {31'd0, reconfigure}, 32'd1);
        wr(6'h08, 32'd5);
        chk("R7 sync write no pulse", {31'd0, reconfigure}, 32'd0);
        wr(6'h00, 32'd1);
        chk("R3 halted again", {31'd0, running}, 32'd0);
        chk("R7 halt write no pulse", {31'd0, reconfigure}, 32'd0);
    endtask

    task automatic t_base();
        logic [31:0] v;
        wr(6'h24, 32'hF000_0040);
        chk("R5 masked base", base_addr, 32'h0000_0040);
        chk("R8 refresh pulse", {31'd0, refresh_req}, 32'd1);
        wr(6'h24, 32'h0000_0104);
        chk("R4 misaligned keeps base", base_addr, 32'h0000_0040);
        chk("R4 misaligned no refresh", {31'd0, refresh_req}, 32'd0);
        wr(6'h24, 32'h0000_0110);
        chk("R4 bit4 set keeps base", base_addr, 32'h0000_0040);
        rd(6'h28, v);
        chk("R6 live base read", v, 32'h0000_0040);
        wr(6'h28, 32'h1234_5600);
        chk("R6 live write ignored", base_addr, 32'h0000_0040);
        rd(6'h24, v);
        chk("R6 base after live write", v, 32'h0000_0040);
    endtask

    task automatic t_bad();
        logic [31:0] v;
        wr(6'h38, 32'hDEAD_BEE0);
        chk("R10 bad write flag", {31'd0, bad_access}, 32'd1);
        rd(6'h38, v);
        chk("R10 bad read zero", v, 32'd0);
        chk("R10 bad read flag", {31'd0, bad_access}, 32'd1);
        wr(6'h06, 32'd99);
        chk("R10 partial write flag", {31'd0, bad_access}, 32'd1);
        chk("R10 partial write no stride change", line_stride, 32'd1600);
        rd(6'h04, v);
        chk("R10 hres untouched", v, 32'd800);
        chk("R10 good access no flag", {31'd0, bad_access}, 32'd0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        wr(6'h30, 32'h1111_0000);
        @(negedge clk);
        rd_en = 1'b1; wr_en = 1'b1; addr = 6'h30; wdata = 32'h2222_0000;
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        chk("R12 read returns old", rdata, 32'h1111_0000);
        rd(6'h30, v);
        chk("R12 new value after", v, 32'h2222_0000);
    endtask

    task automatic t_sync_reset();
        logic [31:0] v;
        wr(6'h00, 32'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 running cleared", {31'd0, running}, 32'd0);
        chk("R11 base cleared", base_addr, 32'd0);
        chk("R11 stride restored", line_stride, 32'd1280);
        rd(6'h14, v);
        chk("R11 vres restored", v, 32'd480);
        rd(6'h30, v);
        chk("R11 ddc cleared", v, 32'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset_values();
        t_map_order();
        t_run_reconfig();
        t_base();
        t_bad();
        t_same_cycle();
        t_sync_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule